// File: doc/BRIEF.md
# SDRAM Command Decoder and Two-Bank State Tracker

This block is the front end of an SDRAM device model. On each rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable pins and a 12-bit address bus. It decodes them into one command per cycle and keeps the open or closed state of two banks, with the row latched in each open bank. The decoded command leaves the block as a registered one-cycle pulse, together with the bank index, the row and the starting column, so that array and datapath logic further down can act on it.

The block also enforces the ordering rules of the bank state machine. No access is allowed before the mode has been programmed. A bank may only be opened while it is idle and only read or written while it is open. Refresh and mode programming need every bank to be closed. A command that breaks one of these rules produces no pulse and changes no state, and it sets a sticky protocol-error flag. Timing windows other than cycle order are left to other logic.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Pins (cs_n, ras_n, cas_n, we_n) decode as follows: LLLL mode set, LLLH refresh, LLHL precharge, LLHH activate, LHLL write, LHLH read, LHHL burst stop, LHHH no operation. A legal command raises its output pulse for exactly the one cycle after the sampling edge, and at most one command pulse is high at a time. bank_o, row_o and col_o hold their values until a command updates them.
- R2: With cs_n high the cycle is ignored. No pulse is raised, and the bank states, rows, mode and error flag keep their values.
- R3: Activate opens the bank given by addr[11] and latches addr[10:0] as its row. It reports that bank and row on bank_o and row_o.
- R4: Read and write report addr[11] on bank_o, addr[7:0] on col_o, and the row latched in that bank on row_o.
- R5: Precharge with addr[10] high closes both banks and raises pre_all_o along with pre_o. With addr[10] low it closes only bank addr[11]. Precharging a bank that is already idle is legal.
- R6: A read or write with addr[10] high raises auto_pre_o and closes its bank, unless the stored burst-length code is 111 (full page). In that case addr[10] has no effect and the bank stays open.
- R7: Until the first legal mode set, activate, read, write and refresh are illegal. Mode set stores addr[2:0] as the burst-length code, and it is illegal while any bank is open.
- R8: Read or write to an idle bank, activate to an open bank, and refresh while any bank is open are illegal.
- R9: An illegal command raises no pulse and changes no state. It sets prot_err_o, which stays high until reset.
- R10: After reset all pulses are low, both banks are idle, prot_err_o is low, the mode is unprogrammed, and bank_o, row_o and col_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every input is sampled on its rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 12 | Bank bit 11, precharge-scope bit 10, row 10:0, column 7:0, mode 2:0 |
| act_o | output | 1 | Activate pulse |
| rd_o | output | 1 | Read pulse |
| wr_o | output | 1 | Write pulse |
| pre_o | output | 1 | Precharge pulse |
| pre_all_o | output | 1 | Qualifies pre_o: both banks closed |
| ref_o | output | 1 | Refresh pulse |
| mrs_o | output | 1 | Mode set pulse |
| bst_o | output | 1 | Burst stop pulse |
| auto_pre_o | output | 1 | Qualifies rd_o/wr_o: bank closed after the access |
| bank_o | output | 1 | Bank of the last bank command |
| row_o | output | 11 | Row of the last activate or access |
| col_o | output | 8 | Starting column of the last access |
| bank_active_o | output | 2 | Open flag per bank |
| prot_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench targets precharge scope. If bit 10 were ignored, or bits 10 and 11 were swapped, a single-bank precharge would close the wrong bank or both, and the next access would be reported wrong. Auto-precharge under full-page mode is covered too: a design that always honoured bit 10 would close the bank and flag the next read as illegal. Other cases are access attempts before the mode is set, refresh and mode set with a bank open, and deselected cycles that carry command patterns. A design that got any of these wrong would show a stray pulse, a changed bank flag, or an error flag that is missing or comes too early. Rejected commands are also checked to leave the latched row and column untouched.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_DESL,
        CMD_NOP,
        CMD_MRS,
        CMD_REF,
        CMD_PRE,
        CMD_ACT,
        CMD_WR,
        CMD_RD,
        CMD_BST
    } sdram_cmd_e;

    localparam logic [2:0] BURST_FULL_PAGE = 3'b111;
    localparam int         BURST_CODE_W    = 3;

endpackage

// File: rtl/sdram_pin_decode.sv
module sdram_pin_decode
    import sdram_cmd_pkg::*;
(
    input  logic       cs_ni,
    input  logic       ras_ni,
    input  logic       cas_ni,
    input  logic       we_ni,
    output sdram_cmd_e cmd_o
);

    always_comb begin
        if (cs_ni) begin
            cmd_o = CMD_DESL;
        end else begin
            unique case ({ras_ni, cas_ni, we_ni})
                3'b000:  cmd_o = CMD_MRS;
                3'b001:  cmd_o = CMD_REF;
                3'b010:  cmd_o = CMD_PRE;
                3'b011:  cmd_o = CMD_ACT;
                3'b100:  cmd_o = CMD_WR;
                3'b101:  cmd_o = CMD_RD;
                3'b110:  cmd_o = CMD_BST;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
    parameter int ROW_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             active_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic             active;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (open_i) begin
            slot_d.active = 1'b1;
            slot_d.row    = row_i;
        end else if (close_i) begin
            slot_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign active_o = slot_q.active;
    assign row_o    = slot_q.row;

    // R3: an open request leaves the bank active with the offered row
    assert_open_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        open_i |=> (active_o && row_o == $past(row_i)));

    // R5: a close request alone returns the bank to idle
    assert_close_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (close_i && !open_i) |=> !active_o);

    // R9: without a request the bank state and row do not move
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!open_i && !close_i) |=> ($stable(active_o) && $stable(row_o)));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 8,
    parameter int BANK_W = 1,
    parameter int AP_BIT = 10
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      cs_ni,
    input  logic                      ras_ni,
    input  logic                      cas_ni,
    input  logic                      we_ni,
    input  logic [ROW_W+BANK_W-1:0]   addr_i,
    output logic                      act_o,
    output logic                      rd_o,
    output logic                      wr_o,
    output logic                      pre_o,
    output logic                      pre_all_o,
    output logic                      ref_o,
    output logic                      mrs_o,
    output logic                      bst_o,
    output logic                      auto_pre_o,
    output logic [BANK_W-1:0]         bank_o,
    output logic [ROW_W-1:0]          row_o,
    output logic [COL_W-1:0]          col_o,
    output logic [(1<<BANK_W)-1:0]    bank_active_o,
    output logic                      prot_err_o
);

    localparam int ADDR_W    = ROW_W + BANK_W;
    localparam int NUM_BANKS = 1 << BANK_W;

    typedef struct packed {
        logic                    mode_ok;
        logic [BURST_CODE_W-1:0] burst;
        logic                    err;
        logic                    act;
        logic                    rd;
        logic                    wr;
        logic                    pre;
        logic                    pre_all;
        logic                    refr;
        logic                    mrs;
        logic                    bst;
        logic                    ap;
        logic [BANK_W-1:0]       bank;
        logic [ROW_W-1:0]        row;
        logic [COL_W-1:0]        col;
    } track_t;

    track_t st_d, st_q;

    sdram_cmd_e cmd;

    logic [NUM_BANKS-1:0] open_v;
    logic [NUM_BANKS-1:0] close_v;
    logic [NUM_BANKS-1:0] slot_active;
    logic [ROW_W-1:0]     slot_row [NUM_BANKS];

    logic [BANK_W-1:0] bank_sel;
    logic              sel_active;
    logic              any_active;
    logic              ap_req;

    sdram_pin_decode u_decode (
        .cs_ni  (cs_ni),
        .ras_ni (ras_ni),
        .cas_ni (cas_ni),
        .we_ni  (we_ni),
        .cmd_o  (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_slot #(
            .ROW_W (ROW_W)
        ) u_slot (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .open_i   (open_v[b]),
            .close_i  (close_v[b]),
            .row_i    (addr_i[ROW_W-1:0]),
            .active_o (slot_active[b]),
            .row_o    (slot_row[b])
        );
    end

    assign bank_sel   = addr_i[ADDR_W-1 -: BANK_W];
    assign sel_active = slot_active[bank_sel];
    assign any_active = |slot_active;
    assign ap_req     = addr_i[AP_BIT];

    always_comb begin
        st_d         = st_q;
        st_d.act     = 1'b0;
        st_d.rd      = 1'b0;
        st_d.wr      = 1'b0;
        st_d.pre     = 1'b0;
        st_d.pre_all = 1'b0;
        st_d.refr    = 1'b0;
        st_d.mrs     = 1'b0;
        st_d.bst     = 1'b0;
        st_d.ap      = 1'b0;
        open_v       = '0;
        close_v      = '0;

        unique case (cmd)
            CMD_MRS: begin
                if (any_active) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.mrs     = 1'b1;
                    st_d.mode_ok = 1'b1;
                    st_d.burst   = addr_i[BURST_CODE_W-1:0];
                end
            end
            CMD_REF: begin
                if (!st_q.mode_ok || any_active) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.refr = 1'b1;
                end
            end
            CMD_PRE: begin
                st_d.pre  = 1'b1;
                st_d.bank = bank_sel;
                if (ap_req) begin
                    st_d.pre_all = 1'b1;
                    close_v      = '1;
                end else begin
                    close_v[bank_sel] = 1'b1;
                end
            end
            CMD_ACT: begin
                if (!st_q.mode_ok || sel_active) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.act         = 1'b1;
                    st_d.bank        = bank_sel;
                    st_d.row         = addr_i[ROW_W-1:0];
                    open_v[bank_sel] = 1'b1;
                end
            end
            CMD_RD, CMD_WR: begin
                if (!st_q.mode_ok || !sel_active) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.rd   = (cmd == CMD_RD);
                    st_d.wr   = (cmd == CMD_WR);
                    st_d.bank = bank_sel;
                    st_d.row  = slot_row[bank_sel];
                    st_d.col  = addr_i[COL_W-1:0];
                    if (ap_req && st_q.burst != BURST_FULL_PAGE) begin
                        st_d.ap           = 1'b1;
                        close_v[bank_sel] = 1'b1;
                    end
                end
            end
            CMD_BST: begin
                st_d.bst = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o         = st_q.act;
    assign rd_o          = st_q.rd;
    assign wr_o          = st_q.wr;
    assign pre_o         = st_q.pre;
    assign pre_all_o     = st_q.pre_all;
    assign ref_o         = st_q.refr;
    assign mrs_o         = st_q.mrs;
    assign bst_o         = st_q.bst;
    assign auto_pre_o    = st_q.ap;
    assign bank_o        = st_q.bank;
    assign row_o         = st_q.row;
    assign col_o         = st_q.col;
    assign bank_active_o = slot_active;
    assign prot_err_o    = st_q.err;

    // R1: never more than one command pulse in a cycle
    assert_one_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, bst_o}));

    // R2: a deselected cycle yields no pulse and leaves the banks alone
    assert_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_ni |=> (!act_o && !rd_o && !wr_o && !pre_o && !ref_o && !mrs_o && !bst_o
                   && $stable(bank_active_o) && $stable(prot_err_o)));

    // R5: precharge with the scope bit high leaves every bank idle
    assert_pre_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd == CMD_PRE && ap_req) |=> (bank_active_o == '0 && pre_all_o));

    // R7: activate before the mode is programmed is flagged and refused
    assert_no_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd == CMD_ACT && !st_q.mode_ok) |=> (prot_err_o && !act_o));

    // R8: access to an idle bank is flagged and produces no pulse
    assert_idle_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cmd == CMD_RD || cmd == CMD_WR) && !sel_active) |=> (prot_err_o && !rd_o && !wr_o));

    // R9: the error flag stays set until reset
    assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prot_err_o |=> prot_err_o);

    // R6: auto-precharge pulse only accompanies a read or write
    assert_ap_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        auto_pre_o |-> (rd_o || wr_o));

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic act, rd, wr, pre, pre_all, refr, mrs, bst, ap, bank, err;
    logic [10:0] row;
    logic [7:0]  col;
    logic [1:0]  bact;

    int total = 0;
    int bad = 0;

    // reference model state
    bit         m_act [2];
    logic [10:0] m_row [2];
    bit         m_mode;
    logic [2:0] m_bl;
    bit         m_err;
    logic [8:0] e_pulse;   // act rd wr pre pre_all ref mrs bst ap
    logic       e_bank;
    logic [10:0] e_row;
    logic [7:0] e_col;

    always #5 clk = ~clk;

    sdram_cmd_tracker u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
        .we_ni(we_n), .addr_i(addr), .act_o(act), .rd_o(rd), .wr_o(wr), .pre_o(pre),
        .pre_all_o(pre_all), .ref_o(refr), .mrs_o(mrs), .bst_o(bst), .auto_pre_o(ap),
        .bank_o(bank), .row_o(row), .col_o(col), .bank_active_o(bact), .prot_err_o(err)
    );

    // command codes used by the bench: 0 NOP 1 MRS 2 REF 3 PRE 4 ACT 5 WR 6 RD 7 BST
    function automatic logic [2:0] pins_of(int c);
        case (c)
            1: return 3'b000;
            2: return 3'b001;
            3: return 3'b010;
            4: return 3'b011;
            5: return 3'b100;
            6: return 3'b101;
            7: return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

    function automatic string req_of(bit desel, int c);
        if (desel) return "R2";
        case (c)
            1: return "R7";
            2: return "R8";
            3: return "R5";
            4: return "R3";
            5, 6: return "R4/R6";
            default: return "R1";
        endcase
    endfunction

    task automatic model_reset();
        m_act[0] = 0; m_act[1] = 0; m_row[0] = '0; m_row[1] = '0;
        m_mode = 0; m_bl = '0; m_err = 0;
        e_pulse = '0; e_bank = 0; e_row = '0; e_col = '0;
    endtask

    task automatic model_step(bit desel, int c, logic [11:0] a);
        bit b;
        bit any;
        b = a[11];
        any = m_act[0] | m_act[1];
        e_pulse = '0;
        if (desel) return;
        case (c)
            1: if (any) m_err = 1; else begin e_pulse[2] = 1; m_mode = 1; m_bl = a[2:0]; end
            2: if (!m_mode || any) m_err = 1; else e_pulse[3] = 1;
            3: begin
                e_pulse[5] = 1; e_bank = b;
                if (a[10]) begin e_pulse[4] = 1; m_act[0] = 0; m_act[1] = 0; end
                else m_act[b] = 0;
            end
            4: if (!m_mode || m_act[b]) m_err = 1;
               else begin e_pulse[8] = 1; e_bank = b; e_row = a[10:0]; m_act[b] = 1; m_row[b] = a[10:0]; end
            5, 6: if (!m_mode || !m_act[b]) m_err = 1;
               else begin
                   if (c == 6) e_pulse[7] = 1; else e_pulse[6] = 1;
                   e_bank = b; e_row = m_row[b]; e_col = a[7:0];
                   if (a[10] && m_bl != 3'b111) begin e_pulse[0] = 1; m_act[b] = 0; end
               end
            7: e_pulse[1] = 1;
            default: ;
        endcase
    endtask

    task automatic check_all(string tag);
        logic [8:0] got;
        got = {act, rd, wr, pre, pre_all, refr, mrs, bst, ap};
        total++;
        if (got !== e_pulse || bank !== e_bank || row !== e_row || col !== e_col ||
            bact !== {m_act[1], m_act[0]} || err !== m_err) begin
            bad++;
            $display("FAIL %s: got pulse=%b bank=%0d row=%h col=%h act=%b err=%b exp pulse=%b bank=%0d row=%h col=%h act=%b err=%b",
                     tag, got, bank, row, col, bact, err, e_pulse, e_bank, e_row, e_col,
                     {m_act[1], m_act[0]}, m_err);
        end
    endtask

    task automatic step(bit desel, int c, logic [11:0] a);
        logic [2:0] p;
        @(negedge clk);
        p = pins_of(c);
        cs_n = desel; {ras_n, cas_n, we_n} = p; addr = a;
        model_step(desel, c, a);
        @(posedge clk); #1;
        check_all(req_of(desel, c));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cs_n = 1;
        repeat (2) @(posedge clk);
        #1;
        model_reset();
        check_all("R10");
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: got hang exp finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();
        // R7: activate before mode set
        step(0, 4, 12'h123);
        do_reset();
        step(0, 1, 12'h003);              // R7 mode set, burst 8
        step(0, 4, 12'h5A5);              // R3 bank 0
        step(0, 4, 12'hFFF);              // R3 bank 1 row 7FF
        step(0, 6, 12'h03C);              // R4 read bank 0
        step(1, 4, 12'h800);              // R2 deselected activate pattern
        step(0, 4, 12'h000);              // R8 activate open bank
        step(0, 3, 12'h800);              // R5 single precharge bank 1
        step(0, 6, 12'h83C);              // R8 read idle bank 1
        step(0, 3, 12'h400);              // R5 precharge all
        do_reset();
        step(0, 1, 12'h007);              // R6 full page
        step(0, 4, 12'h811);
        step(0, 5, 12'hC22);              // R6 bit 10 has no effect
        step(0, 6, 12'h833);              // bank still open
        step(0, 2, 12'h000);              // R8 refresh with open bank
        step(0, 3, 12'h400);
        step(0, 1, 12'h002);              // R7 burst 4
        step(0, 4, 12'h044);
        step(0, 5, 12'h455);              // R6 auto-precharge closes bank 0
        step(0, 2, 12'h000);              // refresh legal
        step(0, 7, 12'h000);              // R1 burst stop
        for (int i = 0; i < 4000; i++) begin
            int r;
            int c;
            bit ds;
            logic [11:0] a;
            if (i % 500 == 0) do_reset();
            ds = ($urandom_range(0, 9) == 0);
            r = $urandom_range(0, 99);
            if (r < 25) c = 4; else if (r < 40) c = 6; else if (r < 55) c = 5;
            else if (r < 70) c = 3; else if (r < 80) c = 1; else if (r < 85) c = 2;
            else if (r < 90) c = 7; else c = 0;
            a = 12'($urandom);
            step(ds, c, a);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule